// File: doc/BRIEF.md
# DRAM command timing guard

This block sits between the command scheduler of a memory controller and the DRAM command bus. It stops a command from going out until the required quiet time has passed after one of three events:

- a refresh,
- the clock enable rising when the memory leaves self-refresh,
- the clock enable rising when the memory leaves power-down.

Each quiet time comes from a field of one 32-bit read-write timing word. The scheduler presents one command at a time on a valid/ready handshake. The block raises ready only when the command may go out now.

Back-pressure works as follows. While `req_valid` is high and `req_ready` is low, the command is stalled. The scheduler must hold both `req_valid` and `req_kind` steady until a cycle in which both are high. That cycle is the grant. `req_ready` depends only on the requested kind, the memory type and the timing state. It never depends on `req_valid`, so a scheduler may look at ready before it commits.

Each delay runs on its own down-counter. The counter loads on its event strobe and uses the register value in force at that moment. A strobe that arrives while the counter is still running restarts it. Events apply from the cycle after the strobe: with a programmed value N, the affected commands are stalled for N cycles and may be granted in the cycle after that.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset the timing word reads 0x03C80808, and a request of any kind is granted with no stall.
- R2: Timing word layout: refresh delay in bits 4:0, self-refresh-exit delay for non-read commands in bits 11:8, self-refresh-exit read delay in bits 23:16, power-down-exit delay in bits 27:24. All other bits read as zero, and writing them has no effect.
- R3: After `ev_refresh`, requests of kind activate (1) and kind refresh (2) are stalled for exactly the refresh delay.
- R4: After `ev_sr_exit`, requests of kind activate (1), refresh (2) and other (3) are stalled for exactly the non-read exit delay, on every memory type.
- R5: With `mem_sel` = 1 (DDR), a read (kind 0) after `ev_sr_exit` is stalled for exactly the read exit delay, up to 255 cycles.
- R6: With `mem_sel` = 0 (SDR), 2 (low-power DDR) or 3 (treated as SDR), a read after `ev_sr_exit` is stalled for the non-read exit delay, and the read exit delay has no effect.
- R7: With `mem_sel` = 2, any request after `ev_pd_exit` is stalled for exactly the power-down-exit delay. On other memory types this event stalls nothing.
- R8: A delay programmed as 0 lets the affected command be granted in the first cycle after the event.
- R9: An event repeated while its counter is still nonzero restarts the full delay from that event.
- R10: A write to the timing word while a countdown is running does not change that countdown. Only later events use the new value.
- R11: `cmd_stall` is high exactly in cycles where `req_valid` is high and `req_ready` is low.
- R12: A delay does not affect a kind it does not cover. Reads and other commands are not stalled by a refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Current timing word |
| ev_refresh | input | 1 | A refresh was issued this cycle |
| ev_sr_exit | input | 1 | Clock enable rose on self-refresh exit |
| ev_pd_exit | input | 1 | Clock enable rose on power-down exit |
| mem_sel | input | 2 | Memory type: 0 SDR, 1 DDR, 2 low-power DDR, 3 as SDR |
| req_valid | input | 1 | Command request present |
| req_kind | input | 2 | Request kind: 0 read, 1 activate, 2 refresh, 3 other |
| req_ready | output | 1 | Request may be issued this cycle |
| cmd_stall | output | 1 | Request present but held back |

## Verification
The bench measures the number of stalled cycles before every grant. A guard that is off by one in the load, or that blocks in the event cycle, shows up as one cycle too many or too few. It checks reads on DDR against the long read delay and reads on the other memory types against the short delay. A design that wires the wrong field to reads, or ignores the memory type, would give the wrong wait. It also checks a second event in the middle of a countdown and a register write in the middle of a countdown. A design without a restart would grant early, and one that reloads on a write would grant after the new value. Zero delays, the largest read delay, and the writing of reserved bits are covered as well.

// File: rtl/dcg_pkg.sv
package dcg_pkg;

  localparam int CFG_W   = 32;
  localparam int NUM_DLY = 4;

  // delay slot indices
  localparam int DLY_RFC     = 0;
  localparam int DLY_SRX_ANY = 1;
  localparam int DLY_SRX_RD  = 2;
  localparam int DLY_PDX     = 3;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_ACT   = 2'd1,
    KIND_REF   = 2'd2,
    KIND_OTHER = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    MEM_SDR   = 2'd0,
    MEM_DDR   = 2'd1,
    MEM_LPDDR = 2'd2,
    MEM_RSVD  = 2'd3
  } mem_kind_e;

  function automatic int dly_lsb(input int i);
    case (i)
      DLY_RFC:     return 0;
      DLY_SRX_ANY: return 8;
      DLY_SRX_RD:  return 16;
      default:     return 24;
    endcase
  endfunction

  function automatic int dly_w(input int i);
    case (i)
      DLY_RFC:     return 5;
      DLY_SRX_ANY: return 4;
      DLY_SRX_RD:  return 8;
      default:     return 4;
    endcase
  endfunction

  function automatic int dly_rst(input int i);
    case (i)
      DLY_RFC:     return 8;
      DLY_SRX_ANY: return 8;
      DLY_SRX_RD:  return 200;
      default:     return 3;
    endcase
  endfunction

  function automatic logic [CFG_W-1:0] used_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_DLY; i++) begin
      for (int b = 0; b < dly_w(i); b++) begin
        m[dly_lsb(i) + b] = 1'b1;
      end
    end
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] rst_word();
    logic [CFG_W-1:0] w;
    logic [CFG_W-1:0] f;
    w = '0;
    for (int i = 0; i < NUM_DLY; i++) begin
      f = CFG_W'(dly_rst(i));
      w = w | (f << dly_lsb(i));
    end
    return w;
  endfunction

  // which delay slots guard a given command kind on a given memory type
  function automatic logic [NUM_DLY-1:0] applies(input cmd_kind_e k, input mem_kind_e m);
    logic [NUM_DLY-1:0] a;
    a = '0;
    a[DLY_RFC]     = (k == KIND_ACT) || (k == KIND_REF);
    a[DLY_SRX_ANY] = (k != KIND_READ) || (m != MEM_DDR);
    a[DLY_SRX_RD]  = (k == KIND_READ) && (m == MEM_DDR);
    a[DLY_PDX]     = (m == MEM_LPDDR);
    return a;
  endfunction

endpackage

// File: rtl/dcg_cfg_reg.sv
module dcg_cfg_reg
  import dcg_pkg::*;
#(
  parameter int               WORD_W = CFG_W,
  parameter logic [WORD_W-1:0] MASK  = used_mask(),
  parameter logic [WORD_W-1:0] INIT  = rst_word()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= INIT & MASK;
    end else if (we) begin
      word_q <= wdata & MASK;
    end
  end

  assign q = word_q;

endmodule

// File: rtl/dcg_delay_cnt.sv
module dcg_delay_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/dcg_grant.sv
module dcg_grant
  import dcg_pkg::*;
#(
  parameter int N = NUM_DLY
) (
  input  logic [N-1:0] busy,
  input  logic [1:0]   mem_sel,
  input  logic [1:0]   req_kind,
  input  logic         req_valid,
  output logic         req_ready,
  output logic         cmd_stall
);

  logic [N-1:0] need;

  always_comb begin
    need      = applies(cmd_kind_e'(req_kind), mem_kind_e'(mem_sel));
    req_ready = ~|(need & busy);
    cmd_stall = req_valid & ~req_ready;
  end

endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
  import dcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             ev_refresh,
  input  logic             ev_sr_exit,
  input  logic             ev_pd_exit,
  input  logic [1:0]       mem_sel,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  output logic             req_ready,
  output logic             cmd_stall
);

  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_DLY-1:0] ev_vec;
  logic [NUM_DLY-1:0] busy;

  dcg_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  always_comb begin
    ev_vec              = '0;
    ev_vec[DLY_RFC]     = ev_refresh;
    ev_vec[DLY_SRX_ANY] = ev_sr_exit;
    ev_vec[DLY_SRX_RD]  = ev_sr_exit;
    ev_vec[DLY_PDX]     = ev_pd_exit;
  end

  for (genvar g = 0; g < NUM_DLY; g++) begin : g_dly
    localparam int W   = dly_w(g);
    localparam int LSB = dly_lsb(g);
    dcg_delay_cnt #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ev_vec[g]),
      .load_val (cfg_q[LSB +: W]),
      .busy     (busy[g])
    );
  end

  dcg_grant #(.N(NUM_DLY)) u_grant (
    .busy      (busy),
    .mem_sel   (mem_sel),
    .req_kind  (req_kind),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_stall (cmd_stall)
  );

  assign cfg_rdata = cfg_q;

endmodule

// File: rtl/dram_cmd_guard_chk.sv
module dram_cmd_guard_chk
  import dcg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             ev_refresh,
  input logic             ev_sr_exit,
  input logic             ev_pd_exit,
  input logic [1:0]       mem_sel,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic             req_ready,
  input logic             cmd_stall
);

  localparam logic [CFG_W-1:0] USED = used_mask();

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~USED) == '0);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & USED));

  p_rfc_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_refresh && cfg_rdata[4:0] != 5'd0) |=>
      !(req_valid && req_ready && (req_kind == KIND_ACT || req_kind == KIND_REF)));

  p_srx_nonread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sr_exit && cfg_rdata[11:8] != 4'd0) |=>
      !(req_valid && req_ready && req_kind != KIND_READ));

  p_srx_read_ddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sr_exit && cfg_rdata[23:16] != 8'd0) |=>
      !(req_valid && req_ready && req_kind == KIND_READ && mem_sel == MEM_DDR));

  p_srx_read_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sr_exit && cfg_rdata[11:8] != 4'd0) |=>
      !(req_valid && req_ready && req_kind == KIND_READ && mem_sel != MEM_DDR));

  p_pdx_lp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pd_exit && cfg_rdata[27:24] != 4'd0) |=>
      !(req_valid && req_ready && mem_sel == MEM_LPDDR));

endmodule

bind dram_cmd_guard dram_cmd_guard_chk u_chk (.*);

// File: tb/dram_cmd_guard_tb.sv
`timescale 1ns/1ps
module dram_cmd_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ev_refresh = 1'b0;
  logic        ev_sr_exit = 1'b0;
  logic        ev_pd_exit = 1'b0;
  logic [1:0]  mem_sel = 2'd1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_ready;
  logic        cmd_stall;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];
  int stalls = 0;
  bit stall_bad = 1'b0;

  always #10 clk = ~clk;

  dram_cmd_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ev_refresh(ev_refresh), .ev_sr_exit(ev_sr_exit),
    .ev_pd_exit(ev_pd_exit), .mem_sel(mem_sel), .req_valid(req_valid),
    .req_kind(req_kind), .req_ready(req_ready), .cmd_stall(cmd_stall)
  );

  function automatic logic [31:0] mk(int rfc, int snr, int srd, int xp);
    return (32'(xp) << 24) | (32'(srd) << 16) | (32'(snr) << 8) | 32'(rfc);
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic cfg_write(logic [31:0] w);
    cfg_we = 1'b1;
    cfg_wdata = w;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic check_word(logic [31:0] exp, string tag);
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: cfg_rdata actual %h expected %h", tag, cfg_rdata, exp);
    end
    tick(1);
  endtask

  // 0 refresh, 1 self-refresh exit, 2 power-down exit
  task automatic pulse(int ev);
    ev_refresh = (ev == 0);
    ev_sr_exit = (ev == 1);
    ev_pd_exit = (ev == 2);
    tick(1);
    ev_refresh = 1'b0;
    ev_sr_exit = 1'b0;
    ev_pd_exit = 1'b0;
  endtask

  // driver: pushes the expected stall count, then holds the request until granted
  task automatic request(logic [1:0] kind, int exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_kind = kind;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic run(logic [1:0] mem, int ev, logic [1:0] kind, int exp, string tag);
    tick(300);
    mem_sel = mem;
    pulse(ev);
    request(kind, exp, tag);
  endtask

  // monitor: counts stalled cycles and compares on each grant
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (cmd_stall !== !req_ready) stall_bad = 1'b1;
      if (req_ready) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (stalls != e || stall_bad) begin
          errors++;
          $display("FAIL %s: stalled cycles actual %0d expected %0d (R11 stall flag bad=%0d)",
                   t, stalls, e, stall_bad);
        end
        stalls = 0;
        stall_bad = 1'b0;
      end else begin
        stalls++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset word and immediate grant
    check_word(32'h03C8_0808, "R1");
    request(2'd1, 0, "R1 idle activate");
    // R2: reserved bits dropped
    cfg_write(32'hFFFF_FFFF);
    check_word(32'h0FFF_0F1F, "R2");

    cfg_write(mk(7, 6, 20, 5));
    // R3
    run(2'd1, 0, 2'd1, 7, "R3 activate after refresh");
    run(2'd1, 0, 2'd2, 7, "R3 refresh after refresh");
    // R12
    run(2'd1, 0, 2'd0, 0, "R12 read after refresh");
    run(2'd1, 0, 2'd3, 0, "R12 other after refresh");
    // R4
    run(2'd1, 1, 2'd3, 6, "R4 other after sr exit DDR");
    run(2'd2, 1, 2'd1, 6, "R4 activate after sr exit LPDDR");
    // R5
    run(2'd1, 1, 2'd0, 20, "R5 read after sr exit DDR");
    // R6
    run(2'd0, 1, 2'd0, 6, "R6 read after sr exit SDR");
    run(2'd2, 1, 2'd0, 6, "R6 read after sr exit LPDDR");
    run(2'd3, 1, 2'd0, 6, "R6 read after sr exit type3");
    // R7
    run(2'd2, 2, 2'd3, 5, "R7 other after pd exit LPDDR");
    run(2'd2, 2, 2'd0, 5, "R7 read after pd exit LPDDR");
    run(2'd1, 2, 2'd1, 0, "R7 pd exit ignored on DDR");

    // R9: restart while running
    tick(300);
    mem_sel = 2'd2;
    pulse(2);
    tick(3);
    pulse(2);
    request(2'd3, 5, "R9 restart power-down exit");

    // R10: write during countdown
    cfg_write(mk(7, 10, 20, 5));
    tick(300);
    mem_sel = 2'd1;
    pulse(1);
    cfg_write(mk(7, 1, 20, 5));
    request(2'd3, 9, "R10 write mid countdown");
    run(2'd1, 1, 2'd3, 1, "R10 new value on next event");

    // R8: zero delays
    cfg_write(mk(0, 0, 0, 0));
    run(2'd1, 0, 2'd1, 0, "R8 zero refresh delay");
    run(2'd1, 1, 2'd0, 0, "R8 zero read exit delay");
    run(2'd2, 2, 2'd3, 0, "R8 zero power-down delay");

    // R5 boundary: largest read delay, R3 boundary: largest refresh delay
    cfg_write(mk(31, 15, 255, 15));
    run(2'd1, 1, 2'd0, 255, "R5 read delay 255");
    run(2'd1, 0, 2'd2, 31, "R3 refresh delay 31");

    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule